// File: doc/BRIEF.md
# Glitchless dual clock selector

The block picks one of two free-running clocks and passes it to a true and complement clock output pair. The choice follows a select input, and a change of choice never produces a shortened high pulse. The selector first parks the output low on a falling edge of the clock it is leaving. It then waits until that clock's lane has visibly let go before the lane of the new clock is enabled. Each lane runs only in its own clock domain and sees the other lane's enable through a synchroniser.

A force input exists for the case where one clock may have stopped. While it is high, the output depends only on the lane named by the select input, so a dead clock on the other side cannot stall the change. Raising force drops the output low at once, and the output then restarts on the selected clock. Three asynchronous overrides sit after the clock path. A gate input drives the output pair to a fixed level chosen by a level input. An active-low power-down input drives both outputs high and holds both lanes in reset.

Top module: `glitchfree_clk_sel`

## Requirements
- R1: With force low and the block settled, clk_out follows clk_a when pick_a is 1 and clk_b when pick_a is 0.
- R2: After pick_a changes, the last falling edge of the old clock on clk_out comes no more than three periods of the old clock after the change.
- R3: After that falling edge, clk_out stays low for no more than three periods of the new clock, and it then restarts on a rising edge of the new clock.
- R4: While force is low, every high pulse on clk_out lasts at least half a period of the faster input clock, and the two lane enables are never high together.
- R5: Raising force_pick drives clk_out low within the same instant, whatever phase the clocks are in. The output then follows the clock named by pick_a, even while the other clock is stopped.
- R6: If force is lowered, pick_a is changed and force is raised again, the output goes low at once and then follows the newly named clock.
- R7: While gate_off is 1 and pwrdn_n is 1, clk_out is held at park_level and clk_out_n at its inverse, asynchronously and with the clocks still running.
- R8: park_level 1 gives clk_out=1 and clk_out_n=0 when gated, and park_level 0 gives clk_out=0 and clk_out_n=1.
- R9: While pwrdn_n is 0, clk_out and clk_out_n are both 1 whatever the gate state. When pwrdn_n returns to 1, the lanes restart from reset, so clk_out starts low.
- R10: While rst_n is 0, clk_out is 0 and clk_out_n is 1. After release, the clock named by pick_a comes up without a handshake with the other lane.
- R11: When neither gate_off nor power-down is active, clk_out_n is the inverse of clk_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | First source clock, chosen when pick_a is 1 |
| clk_b | input | 1 | Second source clock, chosen when pick_a is 0 |
| rst_n | input | 1 | Asynchronous active-low reset, released per lane in step with that lane's clock |
| pick_a | input | 1 | Clock choice: 1 selects clk_a, 0 selects clk_b |
| force_pick | input | 1 | When 1, bypasses the cross-lane handshake and uses only the lane named by pick_a |
| gate_off | input | 1 | When 1, the output pair is driven asynchronously to the level set by park_level |
| park_level | input | 1 | Level that clk_out takes while gated; clk_out_n takes the inverse |
| pwrdn_n | input | 1 | Active-low power-down: both outputs high, lanes held in reset |
| clk_out | output | 1 | True side of the selected, gated clock |
| clk_out_n | output | 1 | Complement side of the selected, gated clock |

## Verification
Some properties are checked on every clock edge: the two lane enables are never high at the same time, and a lane enable only rises while the other lane's enable is low. The level overrides for gate and power-down, and the inverse relation of the output pair in normal operation, are also checked on every edge. The bench scenarios cover the timing properties. These are the park-low window of the old clock, the low window of the new clock, and the alignment of the restart edge with the new clock. The scenarios also cover the immediate drop when force is raised, survival of the output while the deselected clock is stopped, and the reset-held restart after power-down. Each of these involves measuring times between edges, which is done in the bench.

// File: rtl/gcs_pkg.sv
`timescale 1ns/1ps
package gcs_pkg;
  // Number of flops in every cross-domain synchroniser.
  localparam int GCS_SYNC_DEFAULT = 2;
  // Number of selectable source clocks.
  localparam int GCS_LANES = 2;

  // Per-lane gating state seen by the output stage.
  typedef struct packed {
    logic en;   // handshake-protected enable, normal switching path
    logic fen;  // force-path enable, ignores the other lane
  } gcs_lane_t;
endpackage

// File: rtl/gcs_sync.sv
`timescale 1ns/1ps
module gcs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain_q;
  logic [TOP:0] chain_d;

  always_comb begin
    chain_d = {chain_q[TOP-1:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[TOP];
endmodule

// File: rtl/gcs_lane.sv
`timescale 1ns/1ps
module gcs_lane
  import gcs_pkg::*;
#(
  parameter int STAGES = GCS_SYNC_DEFAULT
) (
  input  logic      clk_i,
  input  logic      arst_ni,
  input  logic      want_i,
  input  logic      peer_en_i,
  input  logic      force_i,
  output gcs_lane_t lane_o
);
  // Lane-local reset: asserted at once, released on this lane's clock.
  logic lane_rst_n;
  gcs_sync #(.STAGES(STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (arst_ni),
    .d_i    (1'b1),
    .q_o    (lane_rst_n)
  );

  // Request and peer enable brought into this domain.
  logic want_s;
  logic peer_s;
  gcs_sync #(.STAGES(STAGES)) u_want_sync (
    .clk_i  (clk_i),
    .rst_ni (lane_rst_n),
    .d_i    (want_i),
    .q_o    (want_s)
  );
  gcs_sync #(.STAGES(STAGES)) u_peer_sync (
    .clk_i  (clk_i),
    .rst_ni (lane_rst_n),
    .d_i    (peer_en_i),
    .q_o    (peer_s)
  );

  // Normal enable, updated on the falling edge so the AND gate
  // only opens or closes while the clock is low.
  logic en_d;
  logic en_q;
  logic en_ce;

  always_comb begin
    en_d  = want_s & ~peer_s;
    en_ce = en_d ^ en_q;
  end

  always_ff @(negedge clk_i or negedge lane_rst_n) begin
    if (!lane_rst_n) begin
      en_q <= 1'b0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  // Force path: cleared the instant force drops or this lane stops
  // being named, so raising force always starts from a low output.
  logic frc_rst_n;
  logic frc_arm;
  logic fen_d;
  logic fen_q;

  always_comb begin
    frc_rst_n = lane_rst_n & force_i & want_i;
  end

  gcs_sync #(.STAGES(STAGES)) u_frc_sync (
    .clk_i  (clk_i),
    .rst_ni (frc_rst_n),
    .d_i    (1'b1),
    .q_o    (frc_arm)
  );

  always_comb begin
    fen_d = frc_arm;
  end

  always_ff @(negedge clk_i or negedge frc_rst_n) begin
    if (!frc_rst_n) begin
      fen_q <= 1'b0;
    end else if (fen_d != fen_q) begin
      fen_q <= fen_d;
    end
  end

  always_comb begin
    lane_o.en  = en_q;
    lane_o.fen = fen_q;
  end
endmodule

// File: rtl/gcs_outstage.sv
`timescale 1ns/1ps
module gcs_outstage
  import gcs_pkg::*;
(
  input  logic      clk_a_i,
  input  logic      clk_b_i,
  input  logic      pick_a_i,
  input  logic      force_i,
  input  gcs_lane_t lane_a_i,
  input  gcs_lane_t lane_b_i,
  input  logic      gate_i,
  input  logic      level_i,
  input  logic      pwrdn_ni,
  output logic      out_t_o,
  output logic      out_c_o
);
  logic norm_clk;
  logic frc_clk;
  logic core_clk;

  always_comb begin
    norm_clk = (clk_a_i & lane_a_i.en) | (clk_b_i & lane_b_i.en);
    frc_clk  = pick_a_i ? (clk_a_i & lane_a_i.fen) : (clk_b_i & lane_b_i.fen);
    core_clk = force_i ? frc_clk : norm_clk;
  end

  // Override priority: power-down, then gate, then the clock.
  always_comb begin
    if (!pwrdn_ni) begin
      out_t_o = 1'b1;
      out_c_o = 1'b1;
    end else if (gate_i) begin
      out_t_o = level_i;
      out_c_o = ~level_i;
    end else begin
      out_t_o = core_clk;
      out_c_o = ~core_clk;
    end
  end
endmodule

// File: rtl/glitchfree_clk_sel.sv
`timescale 1ns/1ps
module glitchfree_clk_sel
  import gcs_pkg::*;
#(
  parameter int SYNC_STAGES = GCS_SYNC_DEFAULT
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_n,
  input  logic pick_a,
  input  logic force_pick,
  input  logic gate_off,
  input  logic park_level,
  input  logic pwrdn_n,
  output logic clk_out,
  output logic clk_out_n
);
  localparam int LANES = GCS_LANES;

  logic             lane_arst_n;
  logic [LANES-1:0] lane_clk;
  logic [LANES-1:0] lane_want;
  gcs_lane_t        lane_st [LANES];
  logic             en_a;
  logic             en_b;

  always_comb begin
    lane_arst_n = rst_n & pwrdn_n;
    lane_clk    = {clk_b, clk_a};
    lane_want   = {~pick_a, pick_a};
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    gcs_lane #(.STAGES(SYNC_STAGES)) u_lane (
      .clk_i     (lane_clk[i]),
      .arst_ni   (lane_arst_n),
      .want_i    (lane_want[i]),
      .peer_en_i (lane_st[LANES-1-i].en),
      .force_i   (force_pick),
      .lane_o    (lane_st[i])
    );
  end

  always_comb begin
    en_a = lane_st[0].en;
    en_b = lane_st[1].en;
  end

  gcs_outstage u_out (
    .clk_a_i  (clk_a),
    .clk_b_i  (clk_b),
    .pick_a_i (pick_a),
    .force_i  (force_pick),
    .lane_a_i (lane_st[0]),
    .lane_b_i (lane_st[1]),
    .gate_i   (gate_off),
    .level_i  (park_level),
    .pwrdn_ni (pwrdn_n),
    .out_t_o  (clk_out),
    .out_c_o  (clk_out_n)
  );
endmodule

// File: rtl/gcs_chk.sv
`timescale 1ns/1ps
module gcs_chk (
  input logic clk_a,
  input logic clk_b,
  input logic rst_n,
  input logic gate_off,
  input logic park_level,
  input logic pwrdn_n,
  input logic clk_out,
  input logic clk_out_n,
  input logic en_a,
  input logic en_b
);
  // R4
  lanes_exclusive_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
    !(en_a && en_b));

  // R4
  b_rise_after_a_low_chk: assert property (@(negedge clk_b) disable iff (!rst_n)
    $rose(en_b) |-> !en_a);

  // R4
  a_rise_after_b_low_chk: assert property (@(negedge clk_a) disable iff (!rst_n)
    $rose(en_a) |-> !en_b);

  // R9
  pwrdn_both_high_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
    !pwrdn_n |-> (clk_out && clk_out_n));

  // R7
  gate_park_level_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
    (pwrdn_n && gate_off) |-> (clk_out == park_level && clk_out_n == !park_level));

  // R11
  pair_inverse_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
    (pwrdn_n && !gate_off) |-> (clk_out_n == !clk_out));
endmodule

bind glitchfree_clk_sel gcs_chk u_gcs_chk (
  .clk_a      (clk_a),
  .clk_b      (clk_b),
  .rst_n      (rst_n),
  .gate_off   (gate_off),
  .park_level (park_level),
  .pwrdn_n    (pwrdn_n),
  .clk_out    (clk_out),
  .clk_out_n  (clk_out_n),
  .en_a       (en_a),
  .en_b       (en_b)
);

// File: tb/glitchfree_clk_sel_test.sv
`timescale 1ns/1ps
module glitchfree_clk_sel_test;
  localparam real PER_A = 4.0;
  localparam real PER_B = 10.0;
  localparam real SLACK = 0.01;

  // bits: {pwrdn_n, gate_off, park_level, exp clk_out, exp clk_out_n}
  localparam logic [4:0] OVR_VEC [6] = '{
    5'b11110, 5'b11001, 5'b00011, 5'b01111, 5'b01011, 5'b11110
  };

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic a_run = 1'b1;
  logic b_run = 1'b1;
  logic rst_n = 1'b0;
  logic pick_a = 1'b1;
  logic force_pick = 1'b0;
  logic gate_off = 1'b0;
  logic park_level = 1'b0;
  logic pwrdn_n = 1'b1;
  logic clk_out;
  logic clk_out_n;

  int n_vec = 0;
  int n_bad = 0;

  always begin
    #2;
    if (a_run) clk_a = ~clk_a;
  end

  always begin
    #5;
    if (b_run) clk_b = ~clk_b;
  end

  glitchfree_clk_sel uut (
    .clk_a      (clk_a),
    .clk_b      (clk_b),
    .rst_n      (rst_n),
    .pick_a     (pick_a),
    .force_pick (force_pick),
    .gate_off   (gate_off),
    .park_level (park_level),
    .pwrdn_n    (pwrdn_n),
    .clk_out    (clk_out),
    .clk_out_n  (clk_out_n)
  );

  // Edge monitor on clk_out.
  real last_rise = 0.0;
  real last_fall = 0.0;
  real max_gap   = 0.0;
  real gap_start = 0.0;
  real gap_end   = 0.0;
  real min_high  = 1000.0;
  bit  track     = 1'b0;

  always @(posedge clk_out) begin
    if ($realtime - last_fall > max_gap) begin
      max_gap   = $realtime - last_fall;
      gap_start = last_fall;
      gap_end   = $realtime;
    end
    last_rise = $realtime;
  end

  always @(negedge clk_out) begin
    last_fall = $realtime;
    if (track && ($realtime - last_rise) < min_high) min_high = $realtime - last_rise;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
    end
  endtask

  // Compare the output pair with the expected source over 20 samples,
  // taken at half-ns offsets so that no sample falls on a clock edge.
  task automatic follow(input bit want_a, input string req);
    int miss = 0;
    @(posedge clk_a or posedge clk_b);
    #0.5;
    for (int k = 0; k < 20; k++) begin
      logic src;
      src = want_a ? clk_a : clk_b;
      if (clk_out !== src || clk_out_n !== ~src) miss++;
      #1;
    end
    check(miss == 0, req, want_a ? "follow clk_a mismatches" : "follow clk_b mismatches",
          real'(miss), 0.0);
  endtask

  task automatic switch_to(input bit to_a);
    real t0;
    real p_old;
    real p_new;
    int  phase;
    p_old   = to_a ? PER_B : PER_A;
    p_new   = to_a ? PER_A : PER_B;
    max_gap = 0.0;
    t0      = $realtime;
    pick_a  = to_a;
    #100;
    check(gap_start > t0 && gap_start - t0 <= 3.0 * p_old + SLACK, "R2",
          "park delay after select change", gap_start - t0, 3.0 * p_old);
    check(gap_end - gap_start <= 3.0 * p_new + SLACK, "R3",
          "low time before new clock", gap_end - gap_start, 3.0 * p_new);
    phase = int'(gap_end * 10.0) % (to_a ? 40 : 100);
    check(phase == (to_a ? 20 : 50), "R3", "restart phase (x0.1ns)",
          real'(phase), to_a ? 20.0 : 50.0);
    follow(to_a, "R1");
  endtask

  initial begin
    #50000;
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R10: reset state
    #20.5;
    check(clk_out === 1'b0 && clk_out_n === 1'b1, "R10", "out pair in reset",
          real'({clk_out, clk_out_n}), 1.0);
    #0.5;
    rst_n = 1'b1;
    #60;
    follow(1'b1, "R10");
    track = 1'b1;

    // R1/R2/R3: handshake switching both ways, twice
    switch_to(1'b0);
    switch_to(1'b1);
    switch_to(1'b0);
    switch_to(1'b1);
    // R4: no runt during normal switching
    check(min_high >= PER_A / 2.0 - SLACK, "R4", "shortest high pulse",
          min_high, PER_A / 2.0);
    track = 1'b0;

    // R7/R8/R9: override table, clocks running
    foreach (OVR_VEC[v]) begin
      int miss = 0;
      pwrdn_n    = OVR_VEC[v][4];
      gate_off   = OVR_VEC[v][3];
      park_level = OVR_VEC[v][2];
      #0.1;
      for (int k = 0; k < 7; k++) begin
        if (clk_out !== OVR_VEC[v][1] || clk_out_n !== OVR_VEC[v][0]) miss++;
        #1;
      end
      check(miss == 0, OVR_VEC[v][4] ? "R7/R8" : "R9", "override level mismatches",
            real'(miss), 0.0);
    end
    gate_off = 1'b0;
    pwrdn_n  = 1'b1;
    #60;
    follow(1'b1, "R11");

    // R9: power-down resets lane state; output restarts low
    pwrdn_n = 1'b0;
    #20;
    @(posedge clk_a);
    #0.5;
    pwrdn_n = 1'b1;
    #0.2;
    check(clk_out === 1'b0 && clk_out_n === 1'b1, "R9", "out right after power-up",
          real'({clk_out, clk_out_n}), 1.0);
    #60;
    follow(1'b1, "R9");

    // R5: stop clk_b, raise force on clk_a while clk_a is high
    @(negedge clk_b);
    b_run = 1'b0;
    @(posedge clk_a);
    #0.5;
    force_pick = 1'b1;
    #0.1;
    check(clk_out === 1'b0, "R5", "out at force rise", real'(clk_out), 0.0);
    #40;
    follow(1'b1, "R5");

    // R6: drop force, change to clk_b, raise force again
    b_run = 1'b1;
    #30;
    @(posedge clk_b);
    #0.5;
    force_pick = 1'b0;
    #0.5;
    pick_a = 1'b0;
    #0.5;
    force_pick = 1'b1;
    #0.1;
    check(clk_out === 1'b0, "R6", "out at force re-raise", real'(clk_out), 0.0);
    #80;
    follow(1'b0, "R6");

    // R5: deselected clk_a stops while forced onto clk_b
    @(negedge clk_a);
    a_run = 1'b0;
    #30;
    follow(1'b0, "R5");

    // R1: back to normal path on clk_b
    a_run = 1'b1;
    #30;
    force_pick = 1'b0;
    #40;
    follow(1'b0, "R1");

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule